// File: doc/BRIEF.md
# Mode-Dependent Relative Address Generator

This block turns a short relative address into an absolute 15-bit memory address for a stack machine. The caller supplies a 10-bit relative field, a subroutine-level flag, a mark-stack flag, an operation class, and three base registers: the reference-table base, the stack-mark base and the current-instruction-word base. The flags and the leading bits of the field decide which base register is used, how many of the low field bits form the index, and whether that index is added to the base or subtracted from it. Store-class operations take their address from the top-of-stack word instead of the field. When that word's tag bit is set, the word carries an absolute address that passes straight through.

Two modes take their base from a saved stack-mark value. That value sits inside the control word stored seven words above the reference-table base, so the block reads memory first. It has a request/response read port and a start/done handshake toward its caller. Every other mode finishes in the cycle after start. The result stays on the outputs until the next completed operation. A separate flag reports when the addition or subtraction crossed the ends of the 15-bit address space.

Top module: `rel_addr_gen`

## Requirements
- R1: With the subroutine-level flag low, the address is the reference-table base plus all 10 field bits, taken as an unsigned index from 0 to 1023.
- R2: With the subroutine-level flag high and field bit 9 (the leading bit) at 0, the address is the reference-table base plus field bits 8..0, with an index of at most 511.
- R3: With the flag high and field bits 9..8 equal to 2'b10, the address is a stack-mark base plus field bits 7..0, with an index of at most 255.
- R4: With the flag high and field bits 9..7 equal to 3'b111, the address is a stack-mark base minus field bits 6..0, with an index of at most 127.
- R5: With the flag high, field bits 9..7 equal to 3'b110 and op_class 0 (call), the address is the current-instruction-word base plus field bits 6..0.
- R6: For op_class 1 (store), 2 (program release) and 3 (I/O release), the 3'b110 pattern uses the reference-table base in place of the instruction-word base, still adding field bits 6..0.
- R7: For op_class 1, the 10-bit relative value is tos_word bits 9..0 and rel_field is ignored. When tos_word bit 47 is set, the address is tos_word bits 14..0 unchanged and range_err is 0.
- R8: In the R3 and R4 patterns, when mark_flag is high the stack-mark base comes from memory. mem_req rises in the cycle after start, with mem_addr equal to base_r+7 and held stable until mem_rvalid is seen. The base is mem_rdata bits 32..18, and done rises in the second cycle after the response is accepted. When mark_flag is low, the base is base_f.
- R9: Addresses wrap modulo 2^15. range_err is 1 when the addition carries past 0x7FFF or the subtraction borrows below 0, and 0 otherwise.
- R10: In every mode that needs no memory read, done is high in the cycle right after the start cycle.
- R11: A start while busy is ignored. eff_addr and range_err change only together with a done pulse.
- R12: After reset, busy, done, mem_req, range_err and eff_addr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation |
| op_class | input | 2 | 0 call, 1 store, 2 program release, 3 I/O release |
| sub_level | input | 1 | Subroutine-level flag |
| mark_flag | input | 1 | Mark-stack flag |
| rel_field | input | 10 | Relative address field of the instruction |
| tos_word | input | 48 | Top-of-stack word (store class) |
| base_r | input | 15 | Reference-table base |
| base_f | input | 15 | Stack-mark base |
| base_c | input | 15 | Current instruction word address |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 15 | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 48 | Read data word |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Result valid pulse |
| eff_addr | output | 15 | Effective address |
| range_err | output | 1 | Wrap past either end of the address space |

## Verification
The assertions check the handshake on every cycle. A pending read request holds its address until answered. A response leads to done two cycles later. An accepted start gives either done or a read request in the next cycle. The outputs move only with done. The choice of base, the index width, the sign and the range flag show up only in the bench's sweeps. These cover every class, flag and leading-bit pattern, with indices at 0 and each width's maximum, bases near both ends of the address space, and memory replies of varying latency.

// File: rtl/rag_pkg.sv
package rag_pkg;

    localparam int ADDR_W  = 15;
    localparam int FIELD_W = 10;
    localparam int WORD_W  = 48;
    localparam int WIDE_W  = ADDR_W + 1;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [WORD_W-1:0]  word_t;

    typedef enum logic [1:0] {
        OP_CALL    = 2'd0,
        OP_STORE   = 2'd1,
        OP_PRG_REL = 2'd2,
        OP_IO_REL  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        BS_TABLE = 3'd0,
        BS_MARK  = 3'd1,
        BS_SAVED = 3'd2,
        BS_INSTR = 3'd3,
        BS_ABS   = 3'd4
    } base_e;

    typedef struct packed {
        base_e  base;
        field_t index;
        logic   negate;
    } plan_t;

    typedef struct packed {
        addr_t addr;
        logic  err;
    } result_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_CALC = 2'd2
    } seq_e;

    // Picks the base, the index width and the sign for one relative value.
    function automatic plan_t plan_relative(op_e op, logic sub, logic mark, field_t f);
        plan_t p;
        p.negate = 1'b0;
        if (!sub) begin
            p.base  = BS_TABLE;
            p.index = f;
        end else if (!f[FIELD_W-1]) begin
            p.base  = BS_TABLE;
            p.index = f & field_t'(10'h1FF);
        end else if (!f[FIELD_W-2]) begin
            p.base  = mark ? BS_SAVED : BS_MARK;
            p.index = f & field_t'(10'h0FF);
        end else if (!f[FIELD_W-3]) begin
            p.base  = (op == OP_CALL) ? BS_INSTR : BS_TABLE;
            p.index = f & field_t'(10'h07F);
        end else begin
            p.base   = mark ? BS_SAVED : BS_MARK;
            p.index  = f & field_t'(10'h07F);
            p.negate = 1'b1;
        end
        return p;
    endfunction

endpackage

// File: rtl/rag_mode_decode.sv
module rag_mode_decode
    import rag_pkg::*;
#(
    parameter int TAG_POS = 47
) (
    input  logic [1:0]  op_class,
    input  logic        sub_level,
    input  logic        mark_flag,
    input  field_t      rel_field,
    input  word_t       tos_word,
    output plan_t       plan,
    output addr_t       abs_addr
);
    op_e    op;
    field_t src;

    always_comb begin
        op       = op_e'(op_class);
        src      = (op == OP_STORE) ? tos_word[FIELD_W-1:0] : rel_field;
        abs_addr = tos_word[ADDR_W-1:0];
        if (op == OP_STORE && tos_word[TAG_POS]) begin
            plan.base   = BS_ABS;
            plan.index  = '0;
            plan.negate = 1'b0;
        end else begin
            plan = plan_relative(op, sub_level, mark_flag, src);
        end
    end
endmodule

// File: rtl/rag_offset_alu.sv
module rag_offset_alu
    import rag_pkg::*;
(
    input  addr_t   base,
    input  field_t  index,
    input  logic    negate,
    output result_t res
);
    localparam int PAD_W = WIDE_W - FIELD_W;

    logic [WIDE_W-1:0] base_x;
    logic [WIDE_W-1:0] idx_x;
    logic [WIDE_W-1:0] wide;

    always_comb begin
        base_x   = {1'b0, base};
        idx_x    = {{PAD_W{1'b0}}, index};
        wide     = negate ? (base_x - idx_x) : (base_x + idx_x);
        res.addr = wide[ADDR_W-1:0];
        res.err  = wide[WIDE_W-1];
    end
endmodule

// File: rtl/rag_fetch_seq.sv
module rag_fetch_seq
    import rag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic need_fetch,
    input  logic mem_rvalid,
    output logic busy,
    output logic mem_req,
    output logic accept_direct,
    output logic accept_fetch,
    output logic capture_word,
    output logic finish_fetch
);
    seq_e state_q, state_d;

    always_comb begin
        state_d       = state_q;
        accept_direct = 1'b0;
        accept_fetch  = 1'b0;
        capture_word  = 1'b0;
        finish_fetch  = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (start) begin
                    if (need_fetch) begin
                        accept_fetch = 1'b1;
                        state_d      = SQ_WAIT;
                    end else begin
                        accept_direct = 1'b1;
                    end
                end
            end
            SQ_WAIT: begin
                if (mem_rvalid) begin
                    capture_word = 1'b1;
                    state_d      = SQ_CALC;
                end
            end
            SQ_CALC: begin
                finish_fetch = 1'b1;
                state_d      = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end

    assign busy    = (state_q != SQ_IDLE);
    assign mem_req = (state_q == SQ_WAIT);
endmodule

// File: rtl/rel_addr_gen.sv
module rel_addr_gen
    import rag_pkg::*;
#(
    parameter int TAG_POS      = 47,
    parameter int SAVED_LSB    = 18,
    parameter int FRAME_OFFSET = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [1:0]  op_class,
    input  logic        sub_level,
    input  logic        mark_flag,
    input  logic [9:0]  rel_field,
    input  logic [47:0] tos_word,
    input  logic [14:0] base_r,
    input  logic [14:0] base_f,
    input  logic [14:0] base_c,
    output logic        mem_req,
    output logic [14:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [47:0] mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [14:0] eff_addr,
    output logic        range_err
);
    localparam addr_t OFFSET_A = addr_t'(FRAME_OFFSET);

    plan_t   live_plan, plan_q, use_plan;
    addr_t   abs_addr, saved_q, use_base, mem_addr_q;
    result_t alu_res, res_q;
    logic    done_q;
    logic    accept_direct, accept_fetch, capture_word, finish_fetch;
    logic    need_fetch;

    rag_mode_decode #(.TAG_POS(TAG_POS)) u_decode (
        .op_class  (op_class),
        .sub_level (sub_level),
        .mark_flag (mark_flag),
        .rel_field (rel_field),
        .tos_word  (tos_word),
        .plan      (live_plan),
        .abs_addr  (abs_addr)
    );

    assign need_fetch = (live_plan.base == BS_SAVED);

    rag_fetch_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .need_fetch    (need_fetch),
        .mem_rvalid    (mem_rvalid),
        .busy          (busy),
        .mem_req       (mem_req),
        .accept_direct (accept_direct),
        .accept_fetch  (accept_fetch),
        .capture_word  (capture_word),
        .finish_fetch  (finish_fetch)
    );

    always_comb begin
        use_plan = finish_fetch ? plan_q : live_plan;
        unique case (use_plan.base)
            BS_TABLE: use_base = base_r;
            BS_MARK:  use_base = base_f;
            BS_SAVED: use_base = saved_q;
            BS_INSTR: use_base = base_c;
            BS_ABS:   use_base = abs_addr;
            default:  use_base = base_r;
        endcase
    end

    rag_offset_alu u_alu (
        .base   (use_base),
        .index  (use_plan.index),
        .negate (use_plan.negate),
        .res    (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            plan_q     <= '0;
            saved_q    <= '0;
            mem_addr_q <= '0;
            res_q      <= '0;
            done_q     <= 1'b0;
        end else begin
            if (accept_fetch) begin
                plan_q     <= live_plan;
                mem_addr_q <= base_r + OFFSET_A;
            end
            if (capture_word)
                saved_q <= mem_rdata[SAVED_LSB +: ADDR_W];
            done_q <= accept_direct | finish_fetch;
            if (accept_direct | finish_fetch)
                res_q <= alu_res;
        end
    end

    assign mem_addr  = mem_addr_q;
    assign done      = done_q;
    assign eff_addr  = res_q.addr;
    assign range_err = res_q.err;
endmodule

// File: rtl/rag_checker.sv
module rag_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        mem_req,
    input logic [14:0] mem_addr,
    input logic        mem_rvalid,
    input logic        busy,
    input logic        done,
    input logic [14:0] eff_addr,
    input logic        range_err
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_rvalid |=> mem_req); // R8
    AST_REQ_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_rvalid |=> $stable(mem_addr)); // R8
    AST_REPLY_TO_DONE: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_rvalid |=> !done ##1 done); // R8
    AST_START_ACTS: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> done || mem_req); // R10
    AST_NO_DONE_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !done); // R11
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(eff_addr)); // R11
    AST_HOLD_ERR: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(range_err)); // R11
endmodule

bind rel_addr_gen rag_checker u_rag_checker (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .busy       (busy),
    .done       (done),
    .eff_addr   (eff_addr),
    .range_err  (range_err)
);

// File: tb/rel_addr_gen_tb.sv
module rel_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  op_class;
    logic        sub_level, mark_flag;
    logic [9:0]  rel_field;
    logic [47:0] tos_word;
    logic [14:0] base_r, base_f, base_c;
    logic        mem_req;
    logic [14:0] mem_addr;
    logic        mem_rvalid;
    logic [47:0] mem_rdata;
    logic        busy, done;
    logic [14:0] eff_addr;
    logic        range_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rel_addr_gen u_dut (
        .clk(clk), .rst(rst), .start(start), .op_class(op_class),
        .sub_level(sub_level), .mark_flag(mark_flag), .rel_field(rel_field),
        .tos_word(tos_word), .base_r(base_r), .base_f(base_f), .base_c(base_c),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .eff_addr(eff_addr),
        .range_err(range_err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected {err, addr} derived from the requirement text.
    function automatic logic [15:0] model(int op, bit sub, bit mark, logic [9:0] fin,
                                          logic [47:0] tos, logic [14:0] r, logic [14:0] fr,
                                          logic [14:0] c, logic [14:0] sv);
        logic [9:0] f;
        int base, idx, res;
        bit neg;
        if (op == 1 && tos[47]) return {1'b0, tos[14:0]};
        f   = (op == 1) ? tos[9:0] : fin;
        neg = 1'b0;
        if (!sub)            begin base = r; idx = f; end
        else if (!f[9])      begin base = r; idx = f % 512; end
        else if (!f[8])      begin base = mark ? sv : fr; idx = f % 256; end
        else if (!f[7])      begin base = (op == 0) ? c : r; idx = f % 128; end
        else                 begin base = mark ? sv : fr; idx = f % 128; neg = 1'b1; end
        res = neg ? base - idx : base + idx;
        return {(res < 0 || res > 32767) ? 1'b1 : 1'b0, 15'(res)};
    endfunction

    task automatic run_vec(int op, bit sub, bit mark, logic [9:0] f, logic [47:0] tos,
                           logic [14:0] r, logic [14:0] fr, logic [14:0] c, bit poke);
        logic [14:0] sv;
        logic [15:0] exp;
        int lat, cyc;
        bit fetched, after;
        string rq;
        sv = 15'($urandom);
        op_class = 2'(op); sub_level = sub; mark_flag = mark; rel_field = f;
        tos_word = tos; base_r = r; base_f = fr; base_c = c;
        exp = model(op, sub, mark, f, tos, r, fr, c, sv);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = $urandom_range(0, 3);
        cyc = 0; fetched = 1'b0; after = 1'b0;
        while (!done && cyc < 40) begin
            if (mem_req && !fetched) begin
                if (poke) begin
                    // R11: start while busy with other inputs must be ignored
                    start = 1'b1; rel_field = ~f; base_r = ~r; base_f = ~fr; op_class = 2'd0;
                    poke = 1'b0;
                end
                if (lat == 0) begin
                    check("R8 mem_addr", 32'(mem_addr), 32'(15'(r + 15'd7)));
                    mem_rvalid = 1'b1;
                    mem_rdata  = {15'($urandom), sv, 18'($urandom)};
                    fetched    = 1'b1;
                end else lat--;
                @(negedge clk);
                start = 1'b0; mem_rvalid = 1'b0; mem_rdata = 48'($urandom);
            end else begin
                if (fetched) after = 1'b1;
                @(negedge clk);
            end
            cyc++;
        end
        if (fetched) check("R8 latency after reply", {31'd0, after}, 32'd1);
        else         check("R10 done next cycle", 32'(cyc), 32'd0);
        rq = (op == 1) ? "R7" : (!sub) ? "R1" : (!f[9]) ? "R2" : (!f[8]) ? "R3" :
             (!f[7]) ? ((op == 0) ? "R5" : "R6") : "R4";
        check({rq, " done"}, {31'd0, done}, 32'd1);
        check({rq, " addr"}, 32'(eff_addr), 32'(exp[14:0]));
        check({"R9 range ", rq}, {31'd0, range_err}, {31'd0, exp[15]});
        // R11: outputs hold after done while inputs move
        base_r = 15'($urandom); base_f = 15'($urandom); rel_field = 10'($urandom);
        @(negedge clk);
        check("R11 hold addr", 32'(eff_addr), 32'(exp[14:0]));
        check("R11 no extra done", {31'd0, done}, 32'd0);
    endtask

    initial begin
        logic [9:0] f;
        logic [14:0] r, fr, c;
        logic [6:0] low;
        rst = 1'b1; start = 1'b0; op_class = 2'd0; sub_level = 1'b0; mark_flag = 1'b0;
        rel_field = '0; tos_word = '0; base_r = '0; base_f = '0; base_c = '0;
        mem_rvalid = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 busy", {31'd0, busy}, 32'd0);
        check("R12 done", {31'd0, done}, 32'd0);
        check("R12 mem_req", {31'd0, mem_req}, 32'd0);
        check("R12 eff_addr", 32'(eff_addr), 32'd0);
        check("R12 range_err", {31'd0, range_err}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        for (int op = 0; op < 4; op++)
          for (int sub = 0; sub < 2; sub++)
            for (int mark = 0; mark < 2; mark++)
              for (int top = 0; top < 8; top++)
                for (int ls = 0; ls < 3; ls++)
                  for (int bs = 0; bs < 3; bs++)
                    for (int tg = 0; tg < ((op == 1) ? 2 : 1); tg++) begin
                        low = (ls == 0) ? 7'd0 : (ls == 1) ? 7'h7F : 7'($urandom);
                        f = {3'(top), low};
                        if (bs == 0)      begin r = 15'd100;    fr = 15'd3000;   c = 15'd20000;  end
                        else if (bs == 1) begin r = 15'd5;      fr = 15'd3;      c = 15'd2;      end
                        else              begin r = 15'h7FF0;   fr = 15'h7FFE;   c = 15'h7F80;   end
                        run_vec(op, sub[0], mark[0], (op == 1) ? 10'($urandom) : f,
                                {tg[0], 15'($urandom), 17'($urandom), (op == 1) ? f[9:0] : 10'($urandom)
                                 , 5'($urandom)} >> 5 | {tg[0], 37'd0, f},
                                r, fr, c, (top[2] && mark == 1 && ls == 2));
                    end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule